// File: doc/BRIEF.md
# Lookup-table bus breakpoint matcher

The block watches one processor bus and uses each observed value as the address into a condition memory eight bits wide. Any set of bus values can raise a condition: a single value, a range, or an arbitrary pattern. The block does not compare against one programmed value. The low five bits of the looked-up word are trap sources, and each has its own mask enable. The high three bits leave the block unmasked, so that a later compound-condition stage can combine them with the words from other matchers.

While the processor is halted, a maintenance controller edits the memory in three ways. It can invert one bit at the address currently on the bus. It can clear the whole memory with an internal sweep that writes one address per clock. It can run the same sweep to force one bit to a chosen value across an inclusive address range. A coverage mode works while the processor runs: it sets a designated bit at every value that appears on the bus, so the memory records which values have occurred. The bus width is a parameter. The block is sized for a 16-bit bus, and the default is smaller to keep elaboration light.

The observed bus has no ready signal, because a running processor cannot be stalled. A valid bus cycle is always consumed in the cycle it is presented, so there is no back-pressure. The maintenance strobes and the status outputs are plain level and pulse signals.

Top module: `bpm_matcher`

## Requirements
- R1: In a cycle with bus_valid=1 and cpu_halted=0, the edge stores mem[bus_data][4:0] AND the mask into trap. The mask used is the value held before that edge. trap[i] corresponds to word bit i.
- R2: Reset clears the mask, trap, combo, busy, done and err. After reset no trap occurs, whatever the memory holds.
- R3: In the same kind of cycle as R1, combo receives word bits 7:5 with no mask. Word bit 5 goes to combo[0] and word bit 7 goes to combo[2].
- R4: If a cycle has bus_valid=0 or cpu_halted=1, then trap and combo are zero after the following edge.
- R5: A cmd_toggle strobe accepted while halted and idle inverts word bit cmd_bit at address bus_data in a single edge.
- R6: An accepted cmd_flush writes zero to every address, one address per clock, starting at 0. busy is high for 2^BUS_W cycles. done is high for exactly one cycle, the cycle after the last address is written.
- R7: An accepted cmd_range sweeps every address. It sets word bit cmd_bit to cmd_val at each address a with cmd_lo <= a <= cmd_hi and leaves all other bits and addresses unchanged. If lo > hi, nothing changes. busy and done follow the same timing as in R6.
- R8: With cov_en=1, every cycle with bus_valid=1 and cpu_halted=0 sets word bit 7 at bus_data. trap and combo for that cycle show the word as it was before the bit was set.
- R9: A command strobe is ignored and sets err in three cases: it arrives while running, it arrives while busy, or more than one strobe is high in the same cycle. err stays set until reset.
- R10: A sweep does not advance and does not write during cycles with cpu_halted=0. It resumes where it stopped, so busy lasts longer by the number of stalled cycles.
- R11: mask_wr loads mask_in at the edge. The new mask applies to lookups from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_halted | input | 1 | Processor stopped; enables maintenance writes |
| bus_valid | input | 1 | bus_data carries a processor cycle |
| bus_data | input | BUS_W | Observed bus value, used as the memory address |
| mask_wr | input | 1 | Load the trap mask |
| mask_in | input | N_TRAP | New trap mask |
| cov_en | input | 1 | Coverage marking enable |
| cmd_toggle | input | 1 | Strobe: invert one bit at bus_data |
| cmd_flush | input | 1 | Strobe: clear the whole memory |
| cmd_range | input | 1 | Strobe: force one bit over a range |
| cmd_bit | input | SEL_W | Bit index for toggle and range |
| cmd_val | input | 1 | Value written by range |
| cmd_lo | input | BUS_W | Range start, inclusive |
| cmd_hi | input | BUS_W | Range end, inclusive |
| trap | output | N_TRAP | Registered, masked trap requests |
| combo | output | N_COMBO | Registered unmasked compound-condition bits |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse after the last sweep write |
| err | output | 1 | Sticky flag for a rejected command |

## Verification
A lookup and a coverage write can target the same word in the same cycle. Both use the one read port at bus_data. The bench runs with coverage on, presents one value twice in a row, and checks that combo[2] is 0 after the first cycle and 1 after the second. That result shows the lookup reads the word before the mark is written. The second overlap is a command strobe that arrives while a sweep is running. The bench raises a toggle in the middle of a sweep, then checks that err sets, that the sweep length is unchanged, and that the target word still reads back its old value.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_FLUSH = 2'd1,
    SW_RANGE = 2'd2
  } sweep_kind_e;
endpackage

// File: rtl/bpm_cond_mem.sv
module bpm_cond_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bpm_sweep.sv
module bpm_sweep
  import bpm_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  sweep_kind_e   kind_in,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [SW-1:0] bit_sel,
  input  logic          val,
  input  logic          step_en,
  input  logic [DW-1:0] rdata,
  output logic          active,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic          done
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  sweep_kind_e   kind_q;
  logic [AW-1:0] ptr_q, lo_q, hi_q;
  logic [SW-1:0] bit_q;
  logic          val_q, in_rng, step;

  assign active = (kind_q != SW_IDLE);
  assign step   = active && step_en;
  assign addr   = ptr_q;
  assign in_rng = (ptr_q >= lo_q) && (ptr_q <= hi_q);
  assign we     = step && ((kind_q == SW_FLUSH) || in_rng);

  always_comb begin
    wdata = rdata;
    wdata[bit_q] = val_q;
    if (kind_q == SW_FLUSH) wdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= SW_IDLE;
      ptr_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      bit_q  <= '0;
      val_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        kind_q <= kind_in;
        ptr_q  <= '0;
        lo_q   <= lo;
        hi_q   <= hi;
        bit_q  <= bit_sel;
        val_q  <= val;
      end else if (step) begin
        if (ptr_q == LAST) begin
          kind_q <= SW_IDLE;
          done   <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bpm_trap_gate.sv
module bpm_trap_gate #(
  parameter int NT = 5,
  parameter int NC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic [NT-1:0]    mask_in,
  input  logic             look_en,
  input  logic [NT+NC-1:0] word,
  output logic [NT-1:0]    trap,
  output logic [NC-1:0]    combo,
  output logic [NT-1:0]    mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      trap   <= '0;
      combo  <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_in;
      if (look_en) begin
        trap  <= word[NT-1:0] & mask_q;
        combo <= word[NT+NC-1:NT];
      end else begin
        trap  <= '0;
        combo <= '0;
      end
    end
  end
endmodule

// File: rtl/bpm_matcher.sv
module bpm_matcher
  import bpm_pkg::*;
#(
  parameter int BUS_W   = 10,
  parameter int N_TRAP  = 5,
  parameter int N_COMBO = 3,
  parameter int COV_BIT = 7,
  localparam int DATA_W = N_TRAP + N_COMBO,
  localparam int SEL_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_halted,
  input  logic               bus_valid,
  input  logic [BUS_W-1:0]   bus_data,
  input  logic               mask_wr,
  input  logic [N_TRAP-1:0]  mask_in,
  input  logic               cov_en,
  input  logic               cmd_toggle,
  input  logic               cmd_flush,
  input  logic               cmd_range,
  input  logic [SEL_W-1:0]   cmd_bit,
  input  logic               cmd_val,
  input  logic [BUS_W-1:0]   cmd_lo,
  input  logic [BUS_W-1:0]   cmd_hi,
  output logic [N_TRAP-1:0]  trap,
  output logic [N_COMBO-1:0] combo,
  output logic               busy,
  output logic               done,
  output logic               err
);
  logic [2:0]        strobes;
  logic              any_cmd, cmd_ok, cmd_bad, sw_start, tog_we, run_cyc, cov_we;
  logic              sw_active, sw_we, mem_we;
  logic [BUS_W-1:0]  sw_addr, raddr, mem_wa;
  logic [DATA_W-1:0] rdata, sw_wd, mem_wd, tog_word, cov_word;
  logic [N_TRAP-1:0] mask_q;
  sweep_kind_e       kind_sel;

  assign strobes  = {cmd_range, cmd_flush, cmd_toggle};
  assign any_cmd  = |strobes;
  assign cmd_ok   = cpu_halted && !sw_active && ($countones(strobes) == 1);
  assign cmd_bad  = any_cmd && !cmd_ok;
  assign sw_start = cmd_ok && (cmd_flush || cmd_range);
  assign kind_sel = cmd_flush ? SW_FLUSH : SW_RANGE;
  assign tog_we   = cmd_ok && cmd_toggle;
  assign run_cyc  = bus_valid && !cpu_halted;
  assign cov_we   = cov_en && run_cyc;
  assign raddr    = (sw_active && cpu_halted) ? sw_addr : bus_data;
  assign busy     = sw_active;

  bpm_cond_mem #(.AW(BUS_W), .DW(DATA_W)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr(raddr), .rdata(rdata)
  );

  bpm_sweep #(.AW(BUS_W), .DW(DATA_W), .SW(SEL_W)) sweep_i (
    .clk(clk), .rst_n(rst_n), .start(sw_start), .kind_in(kind_sel),
    .lo(cmd_lo), .hi(cmd_hi), .bit_sel(cmd_bit), .val(cmd_val),
    .step_en(cpu_halted), .rdata(rdata), .active(sw_active),
    .addr(sw_addr), .we(sw_we), .wdata(sw_wd), .done(done)
  );

  bpm_trap_gate #(.NT(N_TRAP), .NC(N_COMBO)) gate_i (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_in(mask_in),
    .look_en(run_cyc), .word(rdata), .trap(trap), .combo(combo),
    .mask_q(mask_q)
  );

  // Write-port selection: the three sources are mutually exclusive by mode.
  always_comb begin
    tog_word          = rdata;
    tog_word[cmd_bit] = ~rdata[cmd_bit];
    cov_word          = rdata;
    cov_word[COV_BIT] = 1'b1;
    mem_we = sw_we;
    mem_wa = sw_addr;
    mem_wd = sw_wd;
    if (!sw_we) begin
      if (tog_we) begin
        mem_we = 1'b1;
        mem_wa = bus_data;
        mem_wd = tog_word;
      end else if (cov_we) begin
        mem_we = 1'b1;
        mem_wa = bus_data;
        mem_wd = cov_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (cmd_bad) err <= 1'b1;
  end
endmodule

// File: rtl/bpm_matcher_chk.sv
module bpm_matcher_chk #(
  parameter int N_TRAP  = 5,
  parameter int N_COMBO = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_halted,
  input logic               bus_valid,
  input logic               cov_en,
  input logic               cmd_toggle,
  input logic               cmd_flush,
  input logic               cmd_range,
  input logic [N_TRAP-1:0]  trap,
  input logic [N_COMBO-1:0] combo,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic [N_TRAP-1:0]  mask_q,
  input logic               mem_we
);
  a_r4_idle_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid || cpu_halted) |=> (trap == '0 && combo == '0));

  a_r1_trap_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((trap & ~$past(mask_q)) != '0) |-> 1'b0);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r9_running_only_coverage: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !cpu_halted) |-> (cov_en && bus_valid));

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r6_flush_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_flush && !cmd_toggle && !cmd_range && cpu_halted && !busy) |=> busy);

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cpu_halted) |=> busy);
endmodule

bind bpm_matcher bpm_matcher_chk #(.N_TRAP(N_TRAP), .N_COMBO(N_COMBO)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_halted(cpu_halted), .bus_valid(bus_valid),
  .cov_en(cov_en), .cmd_toggle(cmd_toggle), .cmd_flush(cmd_flush),
  .cmd_range(cmd_range), .trap(trap), .combo(combo), .busy(busy),
  .done(done), .err(err), .mask_q(mask_q), .mem_we(mem_we)
);

// File: tb/bpm_matcher_tb_top.sv
module bpm_matcher_tb_top;
  localparam int BW = 10;
  localparam int N  = 1 << BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_halted = 1'b1, bus_valid = 1'b0, mask_wr = 1'b0, cov_en = 1'b0;
  logic cmd_toggle = 1'b0, cmd_flush = 1'b0, cmd_range = 1'b0, cmd_val = 1'b0;
  logic [BW-1:0] bus_data = '0, cmd_lo = '0, cmd_hi = '0;
  logic [4:0] mask_in = '0;
  logic [2:0] cmd_bit = '0;
  logic [4:0] trap;
  logic [2:0] combo;
  logic busy, done, err;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bpm_matcher #(.BUS_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_halted(cpu_halted), .bus_valid(bus_valid),
    .bus_data(bus_data), .mask_wr(mask_wr), .mask_in(mask_in), .cov_en(cov_en),
    .cmd_toggle(cmd_toggle), .cmd_flush(cmd_flush), .cmd_range(cmd_range),
    .cmd_bit(cmd_bit), .cmd_val(cmd_val), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .trap(trap), .combo(combo), .busy(busy), .done(done), .err(err)
  );

  // Behavioural reference model
  logic [7:0] mm [N];
  logic [4:0] m_mask, e_trap;
  logic [2:0] e_combo;
  logic e_busy, e_done, e_err, m_flush, m_val;
  int m_ptr, m_lo, m_hi, m_bit;

  initial for (int i = 0; i < N; i++) mm[i] = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; e_trap = 0; e_combo = 0; e_busy = 0; e_done = 0; e_err = 0;
    end else begin
      automatic logic [7:0] w = mm[bus_data];
      automatic int ns = int'(cmd_toggle) + int'(cmd_flush) + int'(cmd_range);
      automatic logic was_busy = e_busy;
      if (bus_valid && !cpu_halted) begin
        e_trap = w[4:0] & m_mask; e_combo = w[7:5];
      end else begin
        e_trap = 0; e_combo = 0;
      end
      if (mask_wr) m_mask = mask_in;
      e_done = 0;
      if (was_busy && cpu_halted) begin
        if (m_flush) mm[m_ptr] = 8'h00;
        else if (m_ptr >= m_lo && m_ptr <= m_hi) mm[m_ptr][m_bit] = m_val;
        if (m_ptr == N - 1) begin e_busy = 0; e_done = 1; end
        else m_ptr++;
      end
      if (ns > 0) begin
        if (!cpu_halted || was_busy || ns > 1) e_err = 1;
        else if (cmd_toggle) mm[bus_data][cmd_bit] = ~mm[bus_data][cmd_bit];
        else begin
          e_busy = 1; m_ptr = 0; m_flush = cmd_flush; m_val = cmd_val;
          m_lo = int'(cmd_lo); m_hi = int'(cmd_hi); m_bit = int'(cmd_bit);
        end
      end
      if (cov_en && bus_valid && !cpu_halted) mm[bus_data][7] = 1'b1;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R1 trap vs model", {3'b0, trap}, {3'b0, e_trap});
      chk("R3 combo vs model", {5'b0, combo}, {5'b0, e_combo});
      chk("R6 busy vs model", {7'b0, busy}, {7'b0, e_busy});
      chk("R6 done vs model", {7'b0, done}, {7'b0, e_done});
      chk("R9 err vs model", {7'b0, err}, {7'b0, e_err});
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic look(logic [BW-1:0] a);
    bus_valid = 1'b1; bus_data = a; step(); #2;
  endtask

  task automatic toggle(logic [BW-1:0] a, logic [2:0] b);
    bus_data = a; cmd_bit = b; cmd_toggle = 1'b1; step(); cmd_toggle = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (3) step(); rst_n = 1'b1; step(); #2;
  endtask

  // stall: halt dropped for 5 cycles; poke: toggle strobe mid-sweep
  task automatic sweep(bit fl, int lo, int hi, int b, bit v, bit stall, bit poke,
                       int exp_len, string tag);
    int cnt = 0;
    bus_valid = 1'b0;
    cmd_lo = BW'(lo); cmd_hi = BW'(hi); cmd_bit = 3'(b); cmd_val = v;
    if (fl) cmd_flush = 1'b1; else cmd_range = 1'b1;
    step(); cmd_flush = 1'b0; cmd_range = 1'b0; #2;
    while (busy && cnt < 4 * N) begin
      cnt++;
      if (stall && cnt == 100) cpu_halted = 1'b0;
      if (stall && cnt == 105) cpu_halted = 1'b1;
      if (poke && cnt == 10) begin bus_data = 'h50; cmd_bit = 3'd4; cmd_toggle = 1'b1; end
      if (poke && cnt == 11) cmd_toggle = 1'b0;
      step(); #2;
    end
    chk({tag, " busy length"}, 8'(cnt / 8), 8'(exp_len / 8));
    chk({tag, " busy length low"}, 8'(cnt % 8), 8'(exp_len % 8));
    chk({tag, " done pulse"}, {7'b0, done}, 8'd1);
    step(); #2;
    chk({tag, " done one cycle"}, {7'b0, done}, 8'd0);
  endtask

  initial begin
    step(); step();
    chk("R2 trap in reset", {3'b0, trap}, 8'h00);
    rst_n = 1'b1; step(); #2;
    chk("R2 busy after reset", {7'b0, busy}, 8'h00);
    chk("R2 err after reset", {7'b0, err}, 8'h00);

    sweep(1, 0, 0, 0, 0, 0, 0, N, "R6 flush");

    toggle('h10, 0); toggle('h20, 2); toggle('h30, 6);
    toggle('h11, 0); toggle('h11, 0);
    mask_wr = 1'b1; mask_in = 5'h1F; step(); mask_wr = 1'b0;

    cpu_halted = 1'b0;
    look('h10); chk("R1 R5 trap at 0x10", {3'b0, trap}, 8'h01);
    look('h20); chk("R1 R5 trap at 0x20", {3'b0, trap}, 8'h04);
    look('h30); chk("R3 combo at 0x30", {5'b0, combo}, 8'h02);
    chk("R1 no trap at 0x30", {3'b0, trap}, 8'h00);
    look('h11); chk("R5 double toggle at 0x11", {3'b0, trap}, 8'h00);

    mask_wr = 1'b1; mask_in = 5'h04; look('h10); mask_wr = 1'b0;
    chk("R11 old mask still used", {3'b0, trap}, 8'h01);
    look('h10); chk("R11 new mask hides bit0", {3'b0, trap}, 8'h00);
    mask_wr = 1'b1; mask_in = 5'h00; look('h20); mask_wr = 1'b0;
    chk("R11 old mask bit2", {3'b0, trap}, 8'h04);
    look('h20); chk("R11 mask zero", {3'b0, trap}, 8'h00);
    mask_wr = 1'b1; mask_in = 5'h1F; step(); mask_wr = 1'b0;

    cpu_halted = 1'b1; look('h10); chk("R4 halted no trap", {3'b0, trap}, 8'h00);
    cpu_halted = 1'b0; bus_valid = 1'b0; bus_data = 'h10; step(); #2;
    chk("R4 invalid no trap", {3'b0, trap}, 8'h00);

    toggle('h10, 0); #2;
    chk("R9 toggle while running sets err", {7'b0, err}, 8'h01);
    look('h10); chk("R9 ignored toggle left word", {3'b0, trap}, 8'h01);

    do_reset();
    look('h10); chk("R2 mask cleared by reset", {3'b0, trap}, 8'h00);
    chk("R2 err cleared by reset", {7'b0, err}, 8'h00);
    mask_wr = 1'b1; mask_in = 5'h1F; step(); mask_wr = 1'b0;

    cpu_halted = 1'b1; bus_data = 'h10; cmd_bit = 0;
    cmd_toggle = 1'b1; cmd_flush = 1'b1; step(); cmd_toggle = 1'b0; cmd_flush = 1'b0; #2;
    chk("R9 two strobes set err", {7'b0, err}, 8'h01);
    chk("R9 two strobes no sweep", {7'b0, busy}, 8'h00);
    cpu_halted = 1'b0; look('h10);
    chk("R9 two strobes left word", {3'b0, trap}, 8'h01);

    do_reset();
    mask_wr = 1'b1; mask_in = 5'h1F; step(); mask_wr = 1'b0;
    cpu_halted = 1'b1;
    sweep(0, 'h100, 'h1FF, 1, 1, 1, 0, N + 5, "R7 R10 range with stall");
    cpu_halted = 1'b0;
    look('hFF);  chk("R7 below range", {3'b0, trap}, 8'h00);
    look('h100); chk("R7 range start", {3'b0, trap}, 8'h02);
    look('h1FF); chk("R7 range end", {3'b0, trap}, 8'h02);
    look('h200); chk("R7 above range", {3'b0, trap}, 8'h00);
    look('h10);  chk("R7 outside bits kept", {3'b0, trap}, 8'h01);

    cpu_halted = 1'b1;
    sweep(0, 'h80, 'h40, 3, 1, 0, 1, N, "R7 R9 empty range with poke");
    chk("R9 strobe while busy sets err", {7'b0, err}, 8'h01);
    cpu_halted = 1'b0;
    look('h60); chk("R7 empty range no change", {3'b0, trap}, 8'h00);
    look('h50); chk("R9 poke while busy ignored", {3'b0, trap}, 8'h00);

    cov_en = 1'b1;
    look('h3F0); chk("R8 first visit shows old word", {5'b0, combo}, 8'h00);
    look('h3F0); chk("R8 second visit shows mark", {5'b0, combo}, 8'h04);
    look('h3F1); chk("R8 neighbour unmarked", {5'b0, combo}, 8'h00);
    cov_en = 1'b0;
    look('h3F1); chk("R8 mark from earlier visit", {5'b0, combo}, 8'h04);
    look('h3F2); chk("R8 no mark when disabled", {5'b0, combo}, 8'h00);
    look('h3F2); chk("R8 still unmarked", {5'b0, combo}, 8'h00);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R6 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule